// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

This block gathers a set of level-sensitive, active-high interrupt requests and passes them through four enable masks. Two of the masks feed a normal interrupt line for each of two processor cores. The other two feed a machine-check line for each core. Nothing is latched and nothing is acknowledged. Each output is a registered OR of the sources that are asserted and enabled. An output therefore falls one clock after the last enabled request is withdrawn, or after its mask bit is cleared.

Software reaches the block through a simple single-cycle register port. A write stores data on the clock edge where the write strobe is high. A read returns data combinationally for the address presented. The raw input levels can be read, and the four masks can be read and written. A convenience register reports the highest-numbered source that is both pending and enabled in core 0's interrupt mask. The highest index has priority, because software services that source first.

Top module: `irqagg_top`

## Requirements
- R1: A read at offset 0x00 returns the present raw level of every source, with source n in bit n and zeros above the source count.
- R2: Offsets 0x10 and 0x14 hold the interrupt masks for cores 0 and 1, and 0x18 and 0x1C hold the machine-check masks for cores 0 and 1. A write stores all 32 data bits on the strobe edge, a read returns the stored value exactly, and a write to one mask leaves the other three unchanged.
- R3: After reset all four masks read zero and all four outputs are low.
- R4: `irq_o[c]` is high in the cycle after a cycle in which any source is high and also enabled in core c's interrupt mask. Otherwise it is low, so it falls one clock after the request is removed or masked, and no acknowledge exists.
- R5: `mchk_o[c]` follows the same rule as R4, using core c's machine-check mask.
- R6: No exclusivity is applied. A source enabled in several masks asserts every matching output in the same cycle.
- R7: A read at offset 0x20 returns, in bits 4:0, the highest source index that is high and enabled in core 0's interrupt mask, with bit 31 clear. When no such source exists it returns bit 31 set and all other bits zero.
- R8: Writes to 0x00, 0x20 or any unmapped offset change no mask. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt requests, active high |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 2 | Interrupt line per core |
| mchk_o | output | 2 | Machine-check line per core |

## Verification
A corrupted mask bit shows up at the ports in two ways. It appears at once in the read-back of that mask. It also appears one clock later as a missing or spurious output when the matching source is driven. A fault in line selection shows as the wrong core's line or the wrong line kind rising while the others stay low. A fault in the priority scan shows as a wrong index in the same cycle as the read. Because every output is a pure registered function of inputs and masks, any fault is visible within one clock of the stimulus that exposes it.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   // Register offsets; each core's mask sits at base + STRIDE * core.
   localparam int OFF_STATUS  = 'h00;
   localparam int OFF_IRQ_MSK = 'h10;
   localparam int OFF_MC_MSK  = 'h18;
   localparam int OFF_HIGHEST = 'h20;
   localparam int OFF_STRIDE  = 4;

   typedef enum logic [1:0] {
      LINE_IRQ  = 2'd0,
      LINE_MCHK = 2'd1
   } line_kind_e;
endpackage

// File: rtl/irqagg_maskbank.sv
module irqagg_maskbank
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_CORES = 2,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic                               wr_en_i,
   input  logic [DATA_W-1:0]                  wdata_i,
   output logic [NUM_CORES-1:0][NUM_SRC-1:0]  irq_mask_o,
   output logic [NUM_CORES-1:0][NUM_SRC-1:0]  mc_mask_o
);
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      localparam logic [ADDR_W-1:0] IRQ_ADDR = ADDR_W'(OFF_IRQ_MSK + OFF_STRIDE * c);
      localparam logic [ADDR_W-1:0] MC_ADDR  = ADDR_W'(OFF_MC_MSK + OFF_STRIDE * c);

      logic irq_hit, mc_hit;
      assign irq_hit = wr_en_i && (addr_i == IRQ_ADDR);
      assign mc_hit  = wr_en_i && (addr_i == MC_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_mask_o[c] <= '0;
            mc_mask_o[c]  <= '0;
         end else begin
            if (irq_hit) irq_mask_o[c] <= wdata_i[NUM_SRC-1:0];
            if (mc_hit)  mc_mask_o[c]  <= wdata_i[NUM_SRC-1:0];
         end
      end
   end
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route #(
   parameter int NUM_SRC   = 32,
   parameter int NUM_LINES = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SRC-1:0]                 src_i,
   input  logic [NUM_LINES-1:0][NUM_SRC-1:0]  mask_i,
   output logic [NUM_LINES-1:0]               line_o
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hit;
      assign hit = |(src_i & mask_i[l]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_o[l] <= 1'b0;
         else        line_o[l] <= hit;
      end
   end
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
   parameter int NUM_SRC = 32,
   parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o
);
   // Scan upward; the last set bit seen is the highest index.
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_CORES = 2,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    src_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_en_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rd_data_o,
   output logic [NUM_CORES-1:0]  irq_o,
   output logic [NUM_CORES-1:0]  mchk_o
);
   localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int NUM_LINES = 2 * NUM_CORES;

   if (NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must fit in DATA_W");
   end
   if (IDX_W >= DATA_W - 1) begin : g_bad_idx
      $error("index field collides with the empty flag");
   end
   if (OFF_IRQ_MSK + OFF_STRIDE * NUM_CORES > OFF_MC_MSK) begin : g_bad_map
      $error("mask banks overlap for this NUM_CORES");
   end

   logic [NUM_CORES-1:0][NUM_SRC-1:0] irq_mask_q;
   logic [NUM_CORES-1:0][NUM_SRC-1:0] mc_mask_q;
   logic [NUM_LINES-1:0][NUM_SRC-1:0] line_mask;
   logic [NUM_LINES-1:0]              line_q;
   logic                              pend_any;
   logic [IDX_W-1:0]                  pend_idx;

   irqagg_maskbank #(
      .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_maskbank (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
      .wdata_i(wdata_i), .irq_mask_o(irq_mask_q), .mc_mask_o(mc_mask_q)
   );

   // Line order: interrupt lines first, then machine-check lines.
   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         line_mask[int'(LINE_IRQ) * NUM_CORES + c]  = irq_mask_q[c];
         line_mask[int'(LINE_MCHK) * NUM_CORES + c] = mc_mask_q[c];
      end
   end

   irqagg_route #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES)) u_route (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_i(line_mask), .line_o(line_q)
   );

   assign irq_o  = line_q[NUM_CORES-1:0];
   assign mchk_o = line_q[NUM_LINES-1:NUM_CORES];

   irqagg_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
      .req_i(src_i & irq_mask_q[0]), .any_o(pend_any), .idx_o(pend_idx)
   );

   always_comb begin
      rd_data_o = '0;
      if (addr_i == ADDR_W'(OFF_STATUS)) rd_data_o = DATA_W'(src_i);
      if (addr_i == ADDR_W'(OFF_HIGHEST)) begin
         rd_data_o[DATA_W-1]  = !pend_any;
         rd_data_o[IDX_W-1:0] = pend_any ? pend_idx : '0;
      end
      for (int c = 0; c < NUM_CORES; c++) begin
         if (addr_i == ADDR_W'(OFF_IRQ_MSK + OFF_STRIDE * c)) rd_data_o = DATA_W'(irq_mask_q[c]);
         if (addr_i == ADDR_W'(OFF_MC_MSK + OFF_STRIDE * c))  rd_data_o = DATA_W'(mc_mask_q[c]);
      end
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int NUM_SRC   = 32,
   parameter int NUM_CORES = 2,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_SRC-1:0]                src_i,
   input logic [ADDR_W-1:0]                 addr_i,
   input logic                              wr_en_i,
   input logic [DATA_W-1:0]                 wdata_i,
   input logic [DATA_W-1:0]                 rd_data_o,
   input logic [NUM_CORES-1:0]              irq_o,
   input logic [NUM_CORES-1:0]              mchk_o,
   input logic [NUM_CORES-1:0][NUM_SRC-1:0] irq_mask_q,
   input logic [NUM_CORES-1:0][NUM_SRC-1:0] mc_mask_q
);
   logic mask_hit, mapped;
   always_comb begin
      mask_hit = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (addr_i == ADDR_W'(OFF_IRQ_MSK + OFF_STRIDE * c)) mask_hit = 1'b1;
         if (addr_i == ADDR_W'(OFF_MC_MSK + OFF_STRIDE * c))  mask_hit = 1'b1;
      end
      mapped = mask_hit || (addr_i == ADDR_W'(OFF_STATUS)) || (addr_i == ADDR_W'(OFF_HIGHEST));
   end

   assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(src_i) == '0) |-> (irq_o == '0 && mchk_o == '0));

   assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_W'(OFF_IRQ_MSK)) |=> (irq_mask_q[0] == $past(wdata_i[NUM_SRC-1:0])));

   assert_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(OFF_HIGHEST) && rd_data_o[DATA_W-1]) |-> (rd_data_o[DATA_W-2:0] == '0));

   assert_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == ADDR_W'(OFF_HIGHEST) && !rd_data_o[DATA_W-1]) |->
         (src_i[rd_data_o[$clog2(NUM_SRC)-1:0]] && irq_mask_q[0][rd_data_o[$clog2(NUM_SRC)-1:0]]));

   assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rd_data_o == '0));

   assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !mask_hit) |=> ($stable(irq_mask_q) && $stable(mc_mask_q)));
endmodule

bind irqagg_top irqagg_chk #(
   .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
   .wdata_i(wdata_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .mchk_o(mchk_o),
   .irq_mask_q(irq_mask_q), .mc_mask_q(mc_mask_q)
);

// File: tb/test_irqagg_top.sv
module test_irqagg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [7:0]  addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rd_data_o;
   logic [1:0]  irq_o, mchk_o;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irqagg_top i_irqagg_top (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
      .wdata_i(wdata_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .mchk_o(mchk_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      addr_i = a;
      #1 d = rd_data_o;
   endtask

   // Drive sources at a falling edge and wait for the next falling edge.
   task automatic drive(logic [31:0] s);
      @(negedge clk);
      src_i = s;
      @(negedge clk);
   endtask

   function automatic logic [31:0] highest(logic [31:0] v);
      logic [31:0] r = 32'h8000_0000;
      for (int i = 31; i >= 0; i--) if (v[i]) begin r = 32'(i); break; end
      return r;
   endfunction

   task automatic t_reset;
      logic [31:0] d;
      check("R3 irq", 32'(irq_o), 0);
      check("R3 mchk", 32'(mchk_o), 0);
      for (int k = 0; k < 4; k++) begin
         rd(8'h10 + 8'(4 * k), d);
         check("R3 mask", d, 0);
      end
   endtask

   task automatic t_status;
      logic [31:0] d;
      logic [31:0] pats [3] = '{32'hA5A5_0F0F, 32'h8000_0001, 32'h0000_0000};
      for (int k = 0; k < 3; k++) begin
         drive(pats[k]);
         rd(8'h00, d);
         check("R1 status", d, pats[k]);
      end
   endtask

   task automatic t_masks;
      logic [31:0] d;
      logic [31:0] vals [4] = '{32'h1234_5678, 32'hFFFF_0000, 32'h8000_0001, 32'h0F0F_F0F0};
      for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4 * k), vals[k]);
      for (int k = 0; k < 4; k++) begin
         rd(8'h10 + 8'(4 * k), d);
         check("R2 readback", d, vals[k]);
      end
      wr(8'h14, 32'hDEAD_BEEF);
      rd(8'h10, d); check("R2 independent", d, vals[0]);
      rd(8'h14, d); check("R2 rewrite", d, 32'hDEAD_BEEF);
      rd(8'h18, d); check("R2 independent", d, vals[2]);
      rd(8'h1C, d); check("R2 independent", d, vals[3]);
      for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4 * k), 0);
   endtask

   task automatic t_level;
      wr(8'h10, 32'h0000_0020);
      drive(32'h0000_0020);
      check("R4 assert core0", 32'(irq_o), 32'b01);
      check("R4 no mchk", 32'(mchk_o), 0);
      drive(32'h0000_0040);
      check("R4 masked src", 32'(irq_o), 0);
      drive(32'h0000_0020);
      drive(32'h0000_0020);
      check("R4 level held", 32'(irq_o), 32'b01);
      drive(0);
      check("R4 drop on removal", 32'(irq_o), 0);
      drive(32'h0000_0020);
      wr(8'h10, 0);
      @(negedge clk);
      check("R4 drop on mask", 32'(irq_o), 0);
      drive(0);
   endtask

   task automatic t_mchk;
      wr(8'h1C, 32'h8000_0000);
      drive(32'h8000_0000);
      check("R5 mchk core1", 32'(mchk_o), 32'b10);
      check("R5 irq quiet", 32'(irq_o), 0);
      drive(0);
      check("R5 drop", 32'(mchk_o), 0);
      wr(8'h1C, 0);
   endtask

   task automatic t_dual;
      wr(8'h10, 32'h0000_0100);
      wr(8'h14, 32'h0000_0100);
      wr(8'h18, 32'h0000_0100);
      wr(8'h1C, 32'h0000_0001);
      drive(32'h0000_0100);
      check("R6 both irq", 32'(irq_o), 32'b11);
      check("R6 mchk core0 only", 32'(mchk_o), 32'b01);
      drive(0);
      for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4 * k), 0);
   endtask

   task automatic t_index;
      logic [31:0] d;
      logic [31:0] pats [5] = '{32'h0000_0001, 32'h8000_0010, 32'h00F0_0000, 32'h0, 32'h4000_0000};
      wr(8'h10, 32'hBFFF_FFFF);
      for (int k = 0; k < 5; k++) begin
         drive(pats[k]);
         rd(8'h20, d);
         check("R7 highest", d, highest(pats[k] & 32'hBFFF_FFFF));
      end
      wr(8'h14, 32'hFFFF_FFFF);
      drive(32'h4000_0000);
      rd(8'h20, d);
      check("R7 core1 mask unused", d, 32'h8000_0000);
      wr(8'h10, 0); wr(8'h14, 0);
      drive(0);
   endtask

   task automatic t_ignored;
      logic [31:0] d;
      wr(8'h10, 32'h0000_0003);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      rd(8'h10, d); check("R8 mask kept", d, 32'h0000_0003);
      for (int k = 0; k < 3; k++) begin
         rd(8'h14 + 8'(4 * k), d);
         check("R8 other masks kept", d, 0);
      end
      drive(32'h0000_0004);
      check("R8 no route", 32'(irq_o), 0);
      check("R8 no mchk", 32'(mchk_o), 0);
      rd(8'h04, d); check("R8 unmapped read", d, 0);
      rd(8'h24, d); check("R8 unmapped read", d, 0);
      rd(8'hFC, d); check("R8 unmapped read", d, 0);
      drive(0);
   endtask

   initial begin
      fork
         begin
            #1 t_reset;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset;
            t_status;
            t_masks;
            t_level;
            t_mchk;
            t_dual;
            t_index;
            t_ignored;
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule